// File: doc/BRIEF.md
# Dual-Mode Decade Ripple Counter

This block is a four-bit decade counter built from two sections that each take their own count input. One section is a toggle stage that divides by two and drives `q0`. The other is a modulo-five stage that drives `q_hi`. A two-bit chain selector decides how the sections are linked:

- In BCD order the toggle output clocks the modulo-five stage, so the four outputs give a binary 0..9.
- In bi-quinary order the top bit of the modulo-five stage clocks the toggle stage, so `q0` becomes a square wave at one tenth of the input rate.
- In split order each section follows its own external input, so the block can divide by 2 and by 5 independently.

All logic runs on one system clock `clk`. Each section's count input is registered once and compared with its previous value. A section advances in the `clk` cycle after its source is seen falling. An internal link is taken straight from the feeding stage's register, so each link adds one `clk` cycle of ripple. `cp0` and `cp1` must be synchronous to `clk`, and each of their high and low phases must last at least two `clk` cycles.

The master clear `mr` is active high and asynchronous, and it overrides every count input. `rst_n` is a synchronous active-low reset for the whole block. `mode` may only be changed while `mr` is high.

Top module: `dec_ripple_counter`

## Requirements
- R1: While `mr` is high, `q0` and `q_hi` read 0 within the same `clk` cycle that `mr` rises, without waiting for a clock edge, and falling edges on `cp0`/`cp1` leave them at 0.
- R2: A section advances only on a high-to-low transition of its selected source. A rising transition, or a source held steady, changes nothing. An external falling edge shows on the outputs at the first `clk` rising edge at which the input is sampled low after being sampled high.
- R3: The toggle stage inverts `q0` once for each falling edge of its source.
- R4: The modulo-five stage steps `q_hi` through 0,1,2,3,4 and then back to 0. `q_hi[2]` falls only on the 4-to-0 wrap.
- R5: `q_hi` never holds a value of 5 or more, and the stage returns to 0 on its next advance from any such value.
- R6: With `mode`=2'b00 (BCD), after n falling edges on `cp0`, the value `{q_hi,q0}` equals n mod 10 with `q0` as the least significant bit, and `cp1` has no effect.
- R7: With `mode`=2'b01 (bi-quinary), after n falling edges on `cp1`, `q_hi` = n mod 5 and `q0` = 1 exactly when n mod 10 is 5 or more, and `cp0` has no effect.
- R8: With `mode[1]`=1 (split), `q0` is the number of `cp0` falling edges mod 2 and `q_hi` is the number of `cp1` falling edges mod 5. Neither input affects the other section.
- R9: `rst_n` low at a `clk` rising edge clears `q0` and `q_hi` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and state changes use its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mr | input | 1 | Asynchronous active-high master clear of both sections |
| mode | input | 2 | Chain order: 00 BCD, 01 bi-quinary, 1x split |
| cp0 | input | 1 | External count input for the toggle stage |
| cp1 | input | 1 | External count input for the modulo-five stage |
| q0 | output | 1 | Toggle stage output |
| q_hi | output | 3 | Modulo-five stage count; bit 2 is its top bit |

## Verification
Each chain order is driven through more than two full decades of input pulses. After every pulse the outputs are compared with counts worked out arithmetically, so a wrong link, a missed wrap or a wrong tenth-rate phase is caught at the exact pulse where it occurs.

In each order, the input that the chain does not use is pulsed on its own, which separates a correct multiplexer from one that leaks the unused input. In split order, a single slow edge is watched cycle by cycle to show that a rising edge does nothing and that a falling edge lands one cycle later.

The master clear is raised in the middle of a cycle and checked before the next edge. The synchronous reset is applied with a count held in the modulo-five stage.

// File: rtl/dec_ripple_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual-mode decade ripple counter.
package dec_ripple_pkg;
    // Chain order selected by the two-bit mode input.
    typedef enum logic [1:0] {
        CHAIN_BCD   = 2'b00,
        CHAIN_BIQ   = 2'b01,
        CHAIN_SPLIT = 2'b10,
        CHAIN_SPLT2 = 2'b11
    } chain_e;
endpackage

// File: rtl/dr_fall_detect.sv
`timescale 1ns/1ps
// Falling-transition detector for one section's count source.
// Assumes src is synchronous to clk. Its previous value clears to 0 under
// either reset, so a source held high across reset release makes no edge.
module dr_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic mr,
    input  logic src,
    output logic fall
);
    logic src_q;

    // Remember the source level from the previous clk edge.
    always_ff @(posedge clk or posedge mr) begin
        if (mr)          src_q <= 1'b0;
        else if (!rst_n) src_q <= 1'b0;
        else             src_q <= src;
    end

    // Report a falling edge when the level was high and is now low.
    assign fall = src_q & ~src;
endmodule

// File: rtl/dr_toggle_stage.sv
`timescale 1ns/1ps
// Divide-by-two section: inverts its output once per advance pulse.
// Assumes adv is a one-cycle strobe from dr_fall_detect.
module dr_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic mr,
    input  logic adv,
    output logic q
);
    // Flip the output on each advance; both resets clear it.
    always_ff @(posedge clk or posedge mr) begin
        if (mr)          q <= 1'b0;
        else if (!rst_n) q <= 1'b0;
        else if (adv)    q <= ~q;
    end

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n || mr)
        adv |=> (q != $past(q))); // R3
    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || mr)
        !adv |=> $stable(q)); // R2
endmodule

// File: rtl/dr_mod_stage.sv
`timescale 1ns/1ps
// Modulo-MOD section: counts advance pulses from 0 up to MOD-1, then wraps.
// Any value at or above MOD-1 returns to 0 on the next advance, so an
// unused code cannot persist.
module dr_mod_stage #(
    parameter  int MOD = 5,
    localparam int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mr,
    input  logic         adv,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt_nx;

    // Next count: wrap from the last legal value (or anything above it).
    always_comb begin
        if (cnt >= LAST) cnt_nx = '0;
        else             cnt_nx = cnt + 1'b1;
    end

    // Count register with asynchronous master clear and synchronous reset.
    always_ff @(posedge clk or posedge mr) begin
        if (mr)          cnt <= '0;
        else if (!rst_n) cnt <= '0;
        else if (adv)    cnt <= cnt_nx;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < (W+1)'(MOD))); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || mr)
        !adv |=> $stable(cnt)); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (adv && cnt == LAST) |=> (cnt == '0)); // R4
    AST_MSB_FALL: assert property (@(posedge clk) disable iff (!rst_n || mr)
        $fell(cnt[W-1]) |-> ($past(cnt) == LAST)); // R4
endmodule

// File: rtl/dec_ripple_counter.sv
`timescale 1ns/1ps
// Dual-mode decade ripple counter top.
// A toggle stage (q0) and a modulo-DIV_HI stage (q_hi) each follow a
// selected count source. In BCD order q0 clocks the upper stage; in
// bi-quinary order the upper stage's top bit clocks q0; in split order
// both follow external inputs. Internal links are taken from stage
// registers, adding one clk of ripple per link. Assumes cp0/cp1 are
// synchronous to clk and mode changes only while mr is high.
module dec_ripple_counter
    import dec_ripple_pkg::*;
#(
    parameter  int DIV_HI = 5,
    localparam int HI_W   = $clog2(DIV_HI)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mr,
    input  logic [1:0]      mode,
    input  logic            cp0,
    input  logic            cp1,
    output logic            q0,
    output logic [HI_W-1:0] q_hi
);
    chain_e chain;
    logic   lo_src, hi_src;
    logic   lo_adv, hi_adv;

    // Decode the chain order and pick each section's count source.
    always_comb begin
        chain  = chain_e'(mode);
        lo_src = (chain == CHAIN_BIQ) ? q_hi[HI_W-1] : cp0;
        hi_src = (chain == CHAIN_BCD) ? q0           : cp1;
    end

    dr_fall_detect u_lo_edge (
        .clk(clk), .rst_n(rst_n), .mr(mr), .src(lo_src), .fall(lo_adv)
    );

    dr_fall_detect u_hi_edge (
        .clk(clk), .rst_n(rst_n), .mr(mr), .src(hi_src), .fall(hi_adv)
    );

    dr_toggle_stage u_lo (
        .clk(clk), .rst_n(rst_n), .mr(mr), .adv(lo_adv), .q(q0)
    );

    dr_mod_stage #(.MOD(DIV_HI)) u_hi (
        .clk(clk), .rst_n(rst_n), .mr(mr), .adv(hi_adv), .cnt(q_hi)
    );

    AST_MR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mr |-> (q0 == 1'b0 && q_hi == '0)); // R1
    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q0 == 1'b0 && q_hi == '0)); // R9
    AST_BCD_NO_CP1: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (chain == CHAIN_BCD && !$past(q0, 1) && !q0) |=> $stable(q_hi)); // R6
endmodule

// File: tb/dec_ripple_counter_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps each chain order with arithmetic expectations.
module dec_ripple_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mr = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       cp0 = 1'b0;
    logic       cp1 = 1'b0;
    logic       q0;
    logic [2:0] q_hi;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk; // 50 MHz

    dec_ripple_counter u_dut (
        .clk(clk), .rst_n(rst_n), .mr(mr), .mode(mode),
        .cp0(cp0), .cp1(cp1), .q0(q0), .q_hi(q_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One slow pulse on cp0 (sel=0) or cp1 (sel=1), then settle.
    task automatic pulse(input int sel);
        @(negedge clk);
        if (sel == 0) cp0 = 1'b1; else cp1 = 1'b1;
        repeat (2) @(negedge clk);
        if (sel == 0) cp0 = 1'b0; else cp1 = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset q0", q0, 0);
        check("R1 reset q_hi", q_hi, 0);
        rst_n = 1'b1;
        mr = 1'b0;

        // R6: BCD order, count on cp0
        for (int i = 1; i <= 23; i++) begin
            pulse(0);
            check("R6 bcd value", {q_hi, q0}, i % 10);
        end
        pulse(1);
        check("R6 cp1 ignored in bcd", {q_hi, q0}, 23 % 10);

        // R1: mid-cycle asynchronous clear, clocks ignored while held
        @(negedge clk);
        #3 mr = 1'b1;
        #2 check("R1 async clear", {q_hi, q0}, 0);
        pulse(0);
        pulse(1);
        check("R1 held under mr", {q_hi, q0}, 0);
        mode = 2'b01;
        @(negedge clk);
        mr = 1'b0;

        // R7: bi-quinary order, count on cp1
        for (int i = 1; i <= 23; i++) begin
            pulse(1);
            check("R7 biq q_hi", q_hi, i % 5);
            check("R7 biq q0", q0, ((i % 10) >= 5) ? 1 : 0);
            check("R5 range", (q_hi < 5) ? 1 : 0, 1);
        end
        pulse(0);
        check("R7 cp0 ignored in biq", {q_hi, q0}, {3'(23 % 5), 1'b0});

        @(negedge clk);
        mr = 1'b1;
        mode = 2'b10;
        @(negedge clk);
        mr = 1'b0;

        // R2: exact edge behaviour in split order
        @(negedge clk);
        cp0 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 rising no change", q0, 0);
        cp0 = 1'b0;
        @(negedge clk);
        check("R2 fall one clk", q0, 1);
        repeat (3) @(negedge clk);
        check("R2 no further change", q0, 1);

        // R8: independent sections
        for (int a = 2; a <= 8; a++) begin
            pulse(0);
            check("R3 toggle", q0, a % 2);
            check("R8 q_hi untouched by cp0", q_hi, 0);
        end
        for (int b = 1; b <= 12; b++) begin
            pulse(1);
            check("R4 split q_hi", q_hi, b % 5);
            check("R8 q0 untouched by cp1", q0, 0);
        end

        // R9: synchronous reset clears a held count
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 sync reset", {q_hi, q0}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule